// File: doc/BRIEF.md
# Sync-Header Serial Frame Parser

This block sits behind a UART receiver and turns its byte stream into distance readings from a ranging sensor. Bytes arrive one per cycle, each qualified by a valid input. The block hunts for two consecutive sync bytes of value 0x59. It then gathers the remaining bytes of a fixed nine-byte frame and checks an additive checksum. Frames that pass release a 16-bit distance together with a one-cycle strobe. Frames that fail bump a saturating error counter.

A status output shows whether the parser is hunting or collecting. The distance output holds the most recent good reading until a newer good frame replaces it. The error counter clears only on reset.

Top module: `range_frame_parser`

## Requirements
- R1: While `rst_n` is low at a clock edge, the parser returns to hunting. After that edge `collecting` is 0, `dist_valid` is 0, `dist_mm` is 0 and `err_count` is 0, and the remembered previous byte is cleared.
- R2: While hunting, `collecting` rises in the cycle after an accepted byte of 0x59 whose previous accepted byte was also 0x59. Any other accepted byte leaves the parser hunting.
- R3: A frame is nine bytes, and the two sync bytes are frame positions 0 and 1. After the sync pair, exactly seven more accepted bytes fill positions 2 to 8. `collecting` falls in the cycle after the byte at position 8.
- R4: A frame is good when the modulo-256 sum of positions 0 to 7 equals the byte at position 8.
- R5: For a good frame, `dist_valid` is high for exactly the one cycle after the position-8 byte. In that same cycle `dist_mm` equals position 3 × 256 + position 2, so the low byte comes first.
- R6: `dist_mm` changes only in a cycle where `dist_valid` is high. Otherwise it holds the last good distance.
- R7: A frame with a checksum mismatch raises no strobe and leaves `dist_mm` unchanged. It increments `err_count` by one in the cycle after its position-8 byte.
- R8: `err_count` is ERR_W bits wide (16 by default) and stays at its all-ones maximum once it gets there.
- R9: When a frame completes, the remembered previous byte is cleared to 0. A single 0x59 right after a frame therefore does not start a new frame, even when the frame's last byte was 0x59.
- R10: Cycles with `in_valid` low are ignored. They neither advance the frame position nor break a sync pair: two 0x59 bytes separated only by idle cycles still count as consecutive.
- R11: While collecting, 0x59 bytes are ordinary frame data and do not restart the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The byte on `in_byte` is accepted this cycle |
| in_byte | input | 8 | Received byte |
| dist_valid | output | 1 | One-cycle strobe: a new good distance is on `dist_mm` |
| dist_mm | output | 16 | Last good distance |
| err_count | output | ERR_W | Saturating count of checksum failures |
| collecting | output | 1 | 1 while collecting a frame, 0 while hunting |

## Verification
The bench goes after the frame boundary. It sends a frame whose checksum byte is 0x59, followed by a lone 0x59. A parser that kept the tail byte would resync one byte early, and every later frame would then come out misaligned and fail its checksum. Idle gaps are placed between the sync bytes and inside frames. A parser that counted idle cycles would end frames early, and one that reset its memory of the previous byte on idle would miss the sync. Frames that carry 0x59 pairs as data catch a parser that restarts mid-frame. A narrow second instance is driven past its counter maximum to catch a wrap to zero. Corrupt frames are mixed into the stream to expose a distance that updates without a strobe.

// File: rtl/frp_pkg.sv
// Package: shared byte type and frame layout constants for the frame parser.
// Assumes: byte-wide input stream; the layout positions are fixed by the sensor protocol.
package frp_pkg;
    typedef logic [7:0] frp_byte_t;
    // Frame positions the datapath decodes (distance low/high byte).
    localparam int FRP_POS_LO = 2;
    localparam int FRP_POS_HI = 3;
endpackage

// File: rtl/frp_sync_detect.sv
// Module: frp_sync_detect
// Watches accepted bytes while hunting and flags the second of two
// consecutive sync bytes. Remembers the last byte accepted while hunting;
// that memory is wiped at every frame end and on reset.
// Assumes: collecting_i comes from the collector's state register.
module frp_sync_detect
    import frp_pkg::*;
#(
    parameter frp_byte_t SYNC_VAL = 8'h59
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  frp_byte_t in_byte,
    input  logic      collecting_i,
    input  logic      frame_end_i,
    output logic      sync_hit_o
);
    frp_byte_t prev_q;

    // Second sync byte seen while hunting.
    assign sync_hit_o = in_valid && !collecting_i &&
                        (in_byte == SYNC_VAL) && (prev_q == SYNC_VAL);

    // Previous-byte memory: cleared at frame end, updated only by hunted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (frame_end_i) begin
            prev_q <= '0;
        end else if (in_valid && !collecting_i) begin
            prev_q <= in_byte;
        end
    end

    // R9: a completed frame leaves no sync byte behind.
    p_prev_wiped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_i |=> (prev_q == '0));

    // R10: idle cycles leave the memory alone.
    p_prev_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(prev_q));
endmodule

// File: rtl/frp_collector.sv
// Module: frp_collector
// Holds the hunting/collecting state and the frame position. It gathers the
// distance bytes and keeps a running modulo-256 sum seeded with both sync
// bytes. At the last position it reports the frame end and whether the
// incoming byte matches the sum.
// Assumes: FRAME_LEN >= 5 so the distance bytes sit before the checksum.
module frp_collector
    import frp_pkg::*;
#(
    parameter int        FRAME_LEN = 9,
    parameter frp_byte_t SYNC_VAL  = 8'h59,
    localparam int       POS_W     = $clog2(FRAME_LEN)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  frp_byte_t   in_byte,
    input  logic        sync_hit_i,
    output logic        collecting_o,
    output logic        frame_end_o,
    output logic        sum_match_o,
    output logic [15:0] dist_word_o
);
    localparam logic [POS_W-1:0] POS_FIRST = POS_W'(FRP_POS_LO);
    localparam logic [POS_W-1:0] POS_HI    = POS_W'(FRP_POS_HI);
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(FRAME_LEN - 1);
    localparam frp_byte_t        SUM_SEED  = SYNC_VAL + SYNC_VAL;

    logic             coll_q;
    logic [POS_W-1:0] pos_q;
    frp_byte_t        sum_q;
    frp_byte_t        lo_q;
    frp_byte_t        hi_q;
    logic             take;

    assign take         = in_valid && coll_q;
    assign frame_end_o  = take && (pos_q == POS_LAST);
    assign sum_match_o  = (sum_q == in_byte);
    assign collecting_o = coll_q;
    assign dist_word_o  = {hi_q, lo_q};

    // State and position: enter on sync, step on each accepted byte, leave at last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll_q <= 1'b0;
            pos_q  <= '0;
        end else if (sync_hit_i) begin
            coll_q <= 1'b1;
            pos_q  <= POS_FIRST;
        end else if (frame_end_o) begin
            coll_q <= 1'b0;
            pos_q  <= '0;
        end else if (take) begin
            pos_q  <= pos_q + 1'b1;
        end
    end

    // Running checksum over positions 0..LAST-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (sync_hit_i) begin
            sum_q <= SUM_SEED;
        end else if (take && (pos_q != POS_LAST)) begin
            sum_q <= sum_q + in_byte;
        end
    end

    // Distance byte capture at their fixed positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (take) begin
            if (pos_q == POS_FIRST) lo_q <= in_byte;
            if (pos_q == POS_HI)    hi_q <= in_byte;
        end
    end

    // R2: collection starts at position 2 after an accepted sync byte.
    p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_q) |-> (pos_q == POS_FIRST) && $past(in_valid) &&
                          ($past(in_byte) == SYNC_VAL));

    // R3: position stays inside the data part of the frame.
    p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        coll_q |-> (pos_q >= POS_FIRST) && (pos_q <= POS_LAST));

    // R10: an idle cycle freezes state and position.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(pos_q) && $stable(coll_q));

    // R11: no restart while collecting below the last position.
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pos_q != POS_LAST) |=> coll_q && (pos_q == $past(pos_q) + 1'b1));
endmodule

// File: rtl/frp_err_counter.sv
// Module: frp_err_counter
// Saturating counter of checksum failures; cleared only by reset.
// Assumes: inc_i is a single-cycle request per failed frame.
module frp_err_counter #(
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [ERR_W-1:0] count_o
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    // Count up on each failure, stick at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (inc_i && (count_o != CNT_MAX)) begin
            count_o <= count_o + 1'b1;
        end
    end

    // R8: maximum is sticky.
    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CNT_MAX) |=> (count_o == CNT_MAX));

    // R7: steps by exactly one on a failure below the maximum.
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && count_o != CNT_MAX) |=> (count_o == $past(count_o) + 1'b1));

    // R7: no failure, no change.
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(count_o));
endmodule

// File: rtl/range_frame_parser.sv
// Module: range_frame_parser (top)
// Extracts distance readings from a ranging sensor's byte stream. It finds a
// two-byte sync header, collects a fixed-length frame and checks an additive
// checksum. A good frame updates a held distance register with a one-cycle
// strobe; a bad frame bumps a saturating error counter.
// Assumes: one byte per cycle at most, qualified by in_valid; no back-pressure.
module range_frame_parser
    import frp_pkg::*;
#(
    parameter int        FRAME_LEN = 9,
    parameter frp_byte_t SYNC_VAL  = 8'h59,
    parameter int        ERR_W     = 16,
    localparam int       DIST_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              dist_valid,
    output logic [DIST_W-1:0] dist_mm,
    output logic [ERR_W-1:0]  err_count,
    output logic              collecting
);
    logic              sync_hit;
    logic              frame_end;
    logic              sum_match;
    logic [DIST_W-1:0] dist_word;
    logic              good_frame;
    logic              bad_frame;

    frp_sync_detect #(.SYNC_VAL(SYNC_VAL)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .collecting_i (collecting),
        .frame_end_i  (frame_end),
        .sync_hit_o   (sync_hit)
    );

    frp_collector #(.FRAME_LEN(FRAME_LEN), .SYNC_VAL(SYNC_VAL)) u_coll (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .sync_hit_i   (sync_hit),
        .collecting_o (collecting),
        .frame_end_o  (frame_end),
        .sum_match_o  (sum_match),
        .dist_word_o  (dist_word)
    );

    assign good_frame = frame_end && sum_match;
    assign bad_frame  = frame_end && !sum_match;

    frp_err_counter #(.ERR_W(ERR_W)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (bad_frame),
        .count_o (err_count)
    );

    // Result register: strobe for one cycle, hold distance until next good frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dist_valid <= 1'b0;
            dist_mm    <= '0;
        end else begin
            dist_valid <= good_frame;
            if (good_frame) dist_mm <= dist_word;
        end
    end

    // R5: strobe never lasts two cycles.
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dist_valid |=> !dist_valid);

    // R6: distance moves only together with the strobe.
    p_dist_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dist_mm) |-> dist_valid);

    // R7: a good-frame strobe never coincides with an error count step.
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dist_valid |-> $stable(err_count));

    // R3: collecting falls only in the cycle after an accepted byte.
    p_leave_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(collecting) |-> $past(in_valid));
endmodule

// File: tb/tb_range_frame_parser.sv
module tb_range_frame_parser;
    localparam logic [7:0] SY = 8'h59;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        dist_valid, collecting, dv4, col4;
    logic [15:0] dist_mm, err_count, dm4;
    logic [3:0]  err4;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit          m_col;
    int          m_pos;
    logic [7:0]  m_prev;
    logic [7:0]  m_buf [9];
    logic [15:0] m_dist;
    logic [15:0] m_err;
    logic [3:0]  m_err4;
    bit          m_strobe;
    logic [7:0]  frm [9];

    always #5 clk = ~clk;

    range_frame_parser dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .dist_valid(dist_valid), .dist_mm(dist_mm), .err_count(err_count),
        .collecting(collecting));

    range_frame_parser #(.ERR_W(4)) dut_sat (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .dist_valid(dv4), .dist_mm(dm4), .err_count(err4), .collecting(col4));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_col = 0; m_pos = 0; m_prev = 8'h00; m_dist = 16'h0;
        m_err = 16'h0; m_err4 = 4'h0; m_strobe = 0;
    endtask

    // model of one accepted byte, written from the requirements
    task automatic model_byte(input logic [7:0] b);
        logic [7:0] s;
        m_strobe = 0;
        if (!m_col) begin
            if (b == SY && m_prev == SY) begin m_col = 1; m_pos = 2; end
            m_prev = b;
        end else begin
            m_buf[m_pos] = b;
            if (m_pos == 8) begin
                m_col = 0; m_prev = 8'h00;
                s = SY + SY;
                for (int i = 2; i < 8; i++) s = s + m_buf[i];
                if (s == b) begin m_dist = {m_buf[3], m_buf[2]}; m_strobe = 1; end
                else begin
                    if (m_err != 16'hFFFF) m_err = m_err + 1'b1;
                    if (m_err4 != 4'hF) m_err4 = m_err4 + 1'b1;
                end
            end else m_pos++;
        end
    endtask

    // one clock: drive at negedge, check after posedge
    task automatic step(input bit v, input logic [7:0] b);
        in_valid = v; in_byte = b;
        if (v) model_byte(b); else m_strobe = 0;
        @(posedge clk); #2;
        check("R2 collecting", collecting, m_col);
        check("R5 dist_valid", dist_valid, m_strobe);
        check("R6 dist_mm", dist_mm, m_dist);
        check("R7 err_count", err_count, m_err);
        check("R8 err_count narrow", err4, m_err4);
        @(negedge clk);
        in_valid = 0;
    endtask

    function automatic logic [7:0] frame_sum();
        logic [7:0] s = 8'h00;
        for (int i = 0; i < 8; i++) s = s + frm[i];
        return s;
    endfunction

    task automatic build(input logic [15:0] d, input bit bad);
        frm[0] = SY; frm[1] = SY; frm[2] = d[7:0]; frm[3] = d[15:8];
        for (int i = 4; i < 8; i++) frm[i] = 8'($urandom_range(0, 255));
        frm[8] = frame_sum() ^ (bad ? 8'h01 << $urandom_range(0, 7) : 8'h00);
    endtask

    task automatic send_frm(input int idle_pct);
        for (int i = 0; i < 9; i++) begin
            while ($urandom_range(0, 99) < idle_pct) step(0, 8'hEE);
            step(1, frm[i]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; in_valid = 0;
        @(posedge clk); @(posedge clk); #2;
        model_reset();
        check("R1 collecting", collecting, 0);
        check("R1 dist_valid", dist_valid, 0);
        check("R1 dist_mm", dist_mm, 0);
        check("R1 err_count", err_count, 0);
        @(negedge clk); rst_n = 1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();

        // R2/R10: sync pair split by idle cycles still starts a frame
        step(1, SY); step(0, 8'h00); step(0, 8'h00); step(1, SY);
        check("R10 sync across idle", collecting, 1);
        frm[0] = SY; frm[1] = SY; frm[2] = 8'h34; frm[3] = 8'h12;
        for (int i = 4; i < 8; i++) frm[i] = 8'h00;
        frm[8] = frame_sum();
        for (int i = 2; i < 9; i++) begin step(0, 8'h00); step(1, frm[i]); end
        check("R5 little-endian distance", dist_mm, 16'h1234);
        check("R3 frame closed", collecting, 0);

        // R2: broken pair does not sync
        step(1, SY); step(1, 8'h12); step(1, SY);
        check("R2 broken pair", collecting, 0);
        step(1, 8'h00);

        // R9: checksum byte 0x59, then a lone 0x59 must not sync
        frm[0] = SY; frm[1] = SY; frm[2] = 8'hA7; frm[3] = 8'h00;
        for (int i = 4; i < 8; i++) frm[i] = 8'h00;
        frm[8] = frame_sum();
        check("R4 crafted checksum is 0x59", frm[8], SY);
        send_frm(0);
        check("R4 good frame", dist_mm, 16'h00A7);
        step(1, SY);
        check("R9 tail not reused", collecting, 0);
        step(1, SY);
        check("R9 fresh pair syncs", collecting, 1);

        // R11: sync bytes inside data do not restart collection
        frm[2] = SY; frm[3] = SY; frm[4] = SY; frm[5] = SY; frm[6] = 8'h01; frm[7] = 8'h02;
        frm[0] = SY; frm[1] = SY; frm[8] = frame_sum();
        for (int i = 2; i < 9; i++) step(1, frm[i]);
        check("R11 data 0x59 kept", dist_mm, 16'h5959);

        // R7: bad frame keeps distance, counts error
        build(16'hBEEF, 1); send_frm(0);
        check("R7 distance kept", dist_mm, 16'h5959);
        check("R7 error counted", err_count, 1);

        // random mix: junk, idles, good and bad frames
        for (int f = 0; f < 400; f++) begin
            int njunk = $urandom_range(0, 3);
            for (int j = 0; j < njunk; j++) step(1, ($urandom_range(0, 3) == 0) ? SY : 8'($urandom_range(0, 255)));
            build(16'($urandom_range(0, 65535)), $urandom_range(0, 99) < 30);
            send_frm(20);
        end
        check("R8 narrow counter saturated", err4, 4'hF);

        // R1: reset in the middle of a frame
        step(1, SY); step(1, SY); step(1, 8'h05);
        do_reset();
        check("R1 post-reset hunting", collecting, 0);
        build(16'h0321, 0); send_frm(10);
        check("R5 frame after reset", dist_mm, 16'h0321);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule